// File: doc/BRIEF.md
# Region Permission Lookaside Checker

This block holds a small, fully associative set of protection region entries and decides, for every memory access, whether the access is allowed. It works on virtual addresses and does not translate them. Each entry describes one contiguous address range and carries a rights mask, a protection-domain (turf) identifier and a thread identifier. Either identifier can be marked "any", so that it matches every requester.

A lookup presents an address, a byte length, an access kind and the requester's turf and thread identifiers. One clock later the block answers with a grant or a fault. Because the latency is fixed and short, the check can run in parallel with a cache lookup. Entries are loaded through a write port that takes an index and an enable. The same module is instantiated twice. The data-side copy serves reads and writes. The instruction-side copy serves execute fetches and portal calls. A parameter selects the side.

Top module: `region_guard`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid`, `rsp_grant` and `rsp_fault` are low and `rsp_idx` is 0, so any lookup issued before an entry is written faults.
- R2: A lookup with `req_valid` high in one cycle gives `rsp_valid` high in the next cycle, with exactly one of `rsp_grant` and `rsp_fault` high. In a cycle after no request, all three are low.
- R3: An entry covers the bytes from `lo` up to but not including `hi`. An access covers `req_len` bytes starting at `req_addr`. The access is covered only if all of its bytes lie inside the entry. The end is computed one bit wider than the address, so it does not wrap. A zero `req_len` always faults.
- R4: Kind codes are 0 read, 1 write, 2 execute, 3 portal. Rights mask bit k permits kind k: bit 0 read, bit 1 write, bit 2 execute, bit 3 portal. An entry grants an access only if the bit for the access's kind is set.
- R5: An entry with neither identifier wildcarded applies only when both its turf and its thread identifier equal the requester's.
- R6: The turf wildcard and the thread wildcard act independently. A wildcarded identifier matches any requester value, and the other identifier must still match.
- R7: Entries may overlap, and the access is granted if any valid entry covers it, applies to the requester and has the right. `rsp_idx` reports the lowest-numbered such entry.
- R8: With `SIDE_INSN`=0 only read and write kinds can be granted. With `SIDE_INSN`=1 only execute and portal kinds can be granted. A kind from the other side faults whatever the entries hold.
- R9: A write with `wr_en` stores the entry at `wr_idx`, and `wr_valid`=0 invalidates it. A lookup issued in the same cycle as the write still sees the old contents. Lookups in later cycles see the new contents.
- R10: On a fault `rsp_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | IDX_W | Entry index to write |
| wr_valid | input | 1 | Valid bit of written entry |
| wr_lo | input | 32 | Inclusive lower bound |
| wr_hi | input | 32 | Exclusive upper bound |
| wr_rights | input | 4 | Rights mask (bit per kind) |
| wr_turf | input | 8 | Turf identifier |
| wr_turf_any | input | 1 | Turf identifier is a wildcard |
| wr_thread | input | 8 | Thread identifier |
| wr_thread_any | input | 1 | Thread identifier is a wildcard |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Virtual start address |
| req_len | input | 4 | Access length in bytes |
| req_kind | input | 2 | Access kind code |
| req_turf | input | 8 | Requester turf identifier |
| req_thread | input | 8 | Requester thread identifier |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access refused |
| rsp_idx | output | IDX_W | Lowest granting entry |

## Verification
Addresses are placed one byte below, on and one byte past each bound, and multi-byte accesses straddle the upper bound. This separates an exclusive upper bound from an inclusive one and whole-access coverage from a start-only check. Requests vary one identifier at a time against entries with no wildcard, a turf wildcard and a thread wildcard, which shows whether each identifier is compared on its own. Overlapping entries, and an access that fits only in the wider of two overlapping entries, test the OR of matches and the lowest-index report. Requests of all four kinds go to both side variants. A write issued in the same cycle as a lookup shows which contents that lookup sees.

// File: rtl/rg_pkg.sv
package rg_pkg;

    localparam int RG_ADDR_W   = 32;
    localparam int RG_TURF_W   = 8;
    localparam int RG_THREAD_W = 8;
    localparam int RG_LEN_W    = 4;
    localparam int RG_KINDS    = 4;

    typedef enum logic [1:0] {
        RG_READ   = 2'd0,
        RG_WRITE  = 2'd1,
        RG_EXEC   = 2'd2,
        RG_PORTAL = 2'd3
    } rg_kind_e;

    typedef struct packed {
        logic                   valid;
        logic [RG_ADDR_W-1:0]   lo;
        logic [RG_ADDR_W-1:0]   hi;
        logic [RG_KINDS-1:0]    rights;
        logic [RG_TURF_W-1:0]   turf;
        logic                   turf_any;
        logic [RG_THREAD_W-1:0] thread;
        logic                   thread_any;
    } rg_entry_t;

    typedef struct packed {
        logic [RG_ADDR_W-1:0]   addr;
        logic [RG_LEN_W-1:0]    len;
        rg_kind_e               kind;
        logic [RG_TURF_W-1:0]   turf;
        logic [RG_THREAD_W-1:0] thread;
    } rg_req_t;

    // Instruction side serves execute and portal; data side serves read and write.
    function automatic logic kind_on_side(input logic side_insn, input logic [1:0] kind);
        return side_insn ? kind[1] : !kind[1];
    endfunction

endpackage

// File: rtl/rg_store.sv
module rg_store
    import rg_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  rg_entry_t               wr_entry,
    output rg_entry_t [ENTRIES-1:0] entries
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                entries[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                entries[g] <= wr_entry;
            end
        end
    end

endmodule

// File: rtl/rg_match.sv
module rg_match
    import rg_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter bit SIDE_INSN = 1'b0
) (
    input  rg_entry_t [ENTRIES-1:0] entries,
    input  rg_req_t                 req,
    output logic [ENTRIES-1:0]      hit
);

    logic [RG_ADDR_W:0] req_end;
    logic               side_ok;

    always_comb begin
        req_end = {1'b0, req.addr} + (RG_ADDR_W+1)'(req.len);
        side_ok = kind_on_side(SIDE_INSN, req.kind) && (req.len != '0);
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic lo_ok, hi_ok, turf_ok, thread_ok, right_ok;
        always_comb begin
            lo_ok     = req.addr >= entries[g].lo;
            hi_ok     = req_end <= {1'b0, entries[g].hi};
            turf_ok   = entries[g].turf_any || (entries[g].turf == req.turf);
            thread_ok = entries[g].thread_any || (entries[g].thread == req.thread);
            right_ok  = entries[g].rights[req.kind];
            hit[g]    = entries[g].valid && side_ok && lo_ok && hi_ok
                        && turf_ok && thread_ok && right_ok;
        end
    end

endmodule

// File: rtl/rg_pick.sv
module rg_pick #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] hit,
    output logic               any,
    output logic [IDX_W-1:0]   first
);

    always_comb begin
        any   = |hit;
        first = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit[i]) first = IDX_W'(i);
        end
    end

endmodule

// File: rtl/region_guard.sv
module region_guard
    import rg_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter bit SIDE_INSN = 1'b0,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic                   wr_valid,
    input  logic [RG_ADDR_W-1:0]   wr_lo,
    input  logic [RG_ADDR_W-1:0]   wr_hi,
    input  logic [RG_KINDS-1:0]    wr_rights,
    input  logic [RG_TURF_W-1:0]   wr_turf,
    input  logic                   wr_turf_any,
    input  logic [RG_THREAD_W-1:0] wr_thread,
    input  logic                   wr_thread_any,
    input  logic                   req_valid,
    input  logic [RG_ADDR_W-1:0]   req_addr,
    input  logic [RG_LEN_W-1:0]    req_len,
    input  logic [1:0]             req_kind,
    input  logic [RG_TURF_W-1:0]   req_turf,
    input  logic [RG_THREAD_W-1:0] req_thread,
    output logic                   rsp_valid,
    output logic                   rsp_grant,
    output logic                   rsp_fault,
    output logic [IDX_W-1:0]       rsp_idx
);

    rg_entry_t                 wr_entry;
    rg_entry_t [ENTRIES-1:0]   entries;
    rg_req_t                   req;
    logic [ENTRIES-1:0]        hit;
    logic                      any_hit;
    logic [IDX_W-1:0]          first_hit;

    always_comb begin
        wr_entry.valid      = wr_valid;
        wr_entry.lo         = wr_lo;
        wr_entry.hi         = wr_hi;
        wr_entry.rights     = wr_rights;
        wr_entry.turf       = wr_turf;
        wr_entry.turf_any   = wr_turf_any;
        wr_entry.thread     = wr_thread;
        wr_entry.thread_any = wr_thread_any;
        req.addr            = req_addr;
        req.len             = req_len;
        req.kind            = rg_kind_e'(req_kind);
        req.turf            = req_turf;
        req.thread          = req_thread;
    end

    rg_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .entries  (entries)
    );

    rg_match #(.ENTRIES(ENTRIES), .SIDE_INSN(SIDE_INSN)) u_match (
        .entries (entries),
        .req     (req),
        .hit     (hit)
    );

    rg_pick #(.ENTRIES(ENTRIES)) u_pick (
        .hit   (hit),
        .any   (any_hit),
        .first (first_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_idx   <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_grant <= req_valid && any_hit;
            rsp_fault <= req_valid && !any_hit;
            rsp_idx   <= (req_valid && any_hit) ? first_hit : '0;
        end
    end

endmodule

// File: rtl/rg_checker.sv
module rg_checker
    import rg_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter bit SIDE_INSN = 1'b0,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [RG_LEN_W-1:0] req_len,
    input logic [1:0]          req_kind,
    input logic                rsp_valid,
    input logic                rsp_grant,
    input logic                rsp_fault,
    input logic [IDX_W-1:0]    rsp_idx
);

    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R2
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R2
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_grant != rsp_fault)); // R2
    AST_NO_STRAY_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_grant && !rsp_fault)); // R2
    AST_ZERO_LEN_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_len == '0) |=> rsp_fault); // R3
    AST_WRONG_SIDE_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !kind_on_side(SIDE_INSN, req_kind)) |=> rsp_fault); // R8
    AST_FAULT_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_idx == '0)); // R10

endmodule

bind region_guard rg_checker #(.ENTRIES(ENTRIES), .SIDE_INSN(SIDE_INSN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_len   (req_len),
    .req_kind  (req_kind),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .rsp_fault (rsp_fault),
    .rsp_idx   (rsp_idx)
);

// File: tb/region_guard_test.sv
module region_guard_test;
    import rg_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 0, wr_valid = 0, wr_turf_any = 0, wr_thread_any = 0;
    logic [3:0]  wr_idx = 0, wr_rights = 0;
    logic [31:0] wr_lo = 0, wr_hi = 0, req_addr = 0;
    logic [7:0]  wr_turf = 0, wr_thread = 0, req_turf = 0, req_thread = 0;
    logic        req_valid = 0;
    logic [3:0]  req_len = 0;
    logic [1:0]  req_kind = 0;
    logic        d_valid, d_grant, d_fault, i_valid, i_grant, i_fault;
    logic [3:0]  d_idx, i_idx;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    region_guard #(.ENTRIES(16), .SIDE_INSN(1'b0)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_rights(wr_rights), .wr_turf(wr_turf),
        .wr_turf_any(wr_turf_any), .wr_thread(wr_thread), .wr_thread_any(wr_thread_any),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len), .req_kind(req_kind),
        .req_turf(req_turf), .req_thread(req_thread),
        .rsp_valid(d_valid), .rsp_grant(d_grant), .rsp_fault(d_fault), .rsp_idx(d_idx));

    region_guard #(.ENTRIES(16), .SIDE_INSN(1'b1)) uut_insn (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_rights(wr_rights), .wr_turf(wr_turf),
        .wr_turf_any(wr_turf_any), .wr_thread(wr_thread), .wr_thread_any(wr_thread_any),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len), .req_kind(req_kind),
        .req_turf(req_turf), .req_thread(req_thread),
        .rsp_valid(i_valid), .rsp_grant(i_grant), .rsp_fault(i_fault), .rsp_idx(i_idx));

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic put(input logic [3:0] idx, input logic v, input logic [31:0] lo,
                       input logic [31:0] hi, input logic [3:0] rights,
                       input logic [7:0] turf, input logic tany,
                       input logic [7:0] thr, input logic hany);
        @(negedge clk);
        wr_en = 1; wr_idx = idx; wr_valid = v; wr_lo = lo; wr_hi = hi;
        wr_rights = rights; wr_turf = turf; wr_turf_any = tany;
        wr_thread = thr; wr_thread_any = hany;
        @(negedge clk);
        wr_en = 0;
    endtask

    // Issues one lookup; results sampled at the negedge after the capturing posedge.
    task automatic look(input logic [31:0] addr, input logic [3:0] len, input logic [1:0] kind,
                        input logic [7:0] turf, input logic [7:0] thr);
        @(negedge clk);
        req_valid = 1; req_addr = addr; req_len = len; req_kind = kind;
        req_turf = turf; req_thread = thr;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic expect_d(input string what, input logic g, input logic [3:0] idx);
        chk({what, " data valid"}, d_valid, 1'b1);
        chk({what, " data grant"}, d_grant, g);
        chk({what, " data fault"}, d_fault, !g);
        chk({what, " data idx"}, d_idx, g ? idx : 4'd0);
    endtask

    task automatic expect_i(input string what, input logic g, input logic [3:0] idx);
        chk({what, " insn grant"}, i_grant, g);
        chk({what, " insn fault"}, i_fault, !g);
        chk({what, " insn idx"}, i_idx, g ? idx : 4'd0);
    endtask

    task automatic t_reset;
        chk("R1 valid after reset", d_valid, 1'b0);
        chk("R1 grant after reset", d_grant, 1'b0);
        chk("R1 fault after reset", d_fault, 1'b0);
        chk("R1 idx after reset", d_idx, 4'd0);
        look(32'h0, 4'd1, 2'd0, 8'd0, 8'd0);
        expect_d("R1 empty lookup", 1'b0, 4'd0);
        @(negedge clk);
        chk("R2 idle no valid", d_valid, 1'b0);
        chk("R2 idle no fault", d_fault, 1'b0);
    endtask

    task automatic t_bounds;
        put(4'd0, 1, 32'h1000, 32'h2000, 4'b0001, 8'd5, 0, 8'd7, 0);
        look(32'h1000, 4'd1, 2'd0, 8'd5, 8'd7); expect_d("R3 at lo", 1, 4'd0);
        look(32'h0FFF, 4'd1, 2'd0, 8'd5, 8'd7); expect_d("R3 below lo", 0, 4'd0);
        look(32'h1FFC, 4'd4, 2'd0, 8'd5, 8'd7); expect_d("R3 last word", 1, 4'd0);
        look(32'h1FFD, 4'd4, 2'd0, 8'd5, 8'd7); expect_d("R3 straddle hi", 0, 4'd0);
        look(32'h2000, 4'd1, 2'd0, 8'd5, 8'd7); expect_d("R3 at hi", 0, 4'd0);
        look(32'h1800, 4'd0, 2'd0, 8'd5, 8'd7); expect_d("R3 zero len", 0, 4'd0);
        look(32'hFFFF_FFFF, 4'd2, 2'd0, 8'd5, 8'd7); expect_d("R3 no wrap", 0, 4'd0);
    endtask

    task automatic t_rights_ids;
        look(32'h1000, 4'd1, 2'd1, 8'd5, 8'd7); expect_d("R4 write on read-only", 0, 4'd0);
        look(32'h1000, 4'd1, 2'd0, 8'd6, 8'd7); expect_d("R5 turf mismatch", 0, 4'd0);
        look(32'h1000, 4'd1, 2'd0, 8'd5, 8'd8); expect_d("R5 thread mismatch", 0, 4'd0);
        put(4'd1, 1, 32'h1000, 32'h2000, 4'b0011, 8'd0, 1, 8'd9, 0);
        look(32'h1004, 4'd2, 2'd1, 8'd3, 8'd9); expect_d("R6 turf wildcard", 1, 4'd1);
        look(32'h1004, 4'd2, 2'd1, 8'd3, 8'd8); expect_d("R6 turf wild thread miss", 0, 4'd0);
        put(4'd2, 1, 32'h1000, 32'h2000, 4'b0001, 8'd4, 0, 8'd0, 1);
        look(32'h1004, 4'd1, 2'd0, 8'd4, 8'd99); expect_d("R6 thread wildcard", 1, 4'd2);
        look(32'h1004, 4'd1, 2'd0, 8'd2, 8'd99); expect_d("R6 thread wild turf miss", 0, 4'd0);
    endtask

    task automatic t_overlap;
        put(4'd3, 1, 32'h1800, 32'h3000, 4'b0001, 8'd0, 1, 8'd0, 1);
        look(32'h1800, 4'd1, 2'd0, 8'd5, 8'd7); expect_d("R7 lowest index", 1, 4'd0);
        look(32'h2800, 4'd1, 2'd0, 8'd5, 8'd7); expect_d("R7 only wide entry", 1, 4'd3);
        look(32'h1FFE, 4'd4, 2'd0, 8'd5, 8'd7); expect_d("R7 fits wide entry", 1, 4'd3);
        look(32'h1004, 4'd1, 2'd0, 8'd4, 8'd7); expect_d("R7 second applies", 1, 4'd2);
    endtask

    task automatic t_sides;
        put(4'd4, 1, 32'h4000, 32'h5000, 4'b1111, 8'd0, 1, 8'd0, 1);
        look(32'h4000, 4'd4, 2'd2, 8'd1, 8'd1);
        expect_d("R8 exec on data side", 0, 4'd0); expect_i("R8 exec on insn side", 1, 4'd4);
        look(32'h4000, 4'd1, 2'd3, 8'd1, 8'd1);
        expect_d("R8 portal on data side", 0, 4'd0); expect_i("R8 portal on insn side", 1, 4'd4);
        look(32'h4010, 4'd8, 2'd1, 8'd1, 8'd1);
        expect_d("R8 write on data side", 1, 4'd4); expect_i("R8 write on insn side", 0, 4'd0);
        look(32'h1000, 4'd4, 2'd2, 8'd5, 8'd7); expect_i("R4 exec on read-only", 0, 4'd0);
    endtask

    task automatic t_write_timing;
        // Invalidate entry 4 in the same cycle as a lookup that it would grant.
        @(negedge clk);
        wr_en = 1; wr_idx = 4'd4; wr_valid = 0; wr_lo = 32'h4000; wr_hi = 32'h5000;
        wr_rights = 4'b1111; wr_turf_any = 1; wr_thread_any = 1;
        req_valid = 1; req_addr = 32'h4000; req_len = 4'd1; req_kind = 2'd0;
        req_turf = 8'd1; req_thread = 8'd1;
        @(negedge clk);
        wr_en = 0; req_valid = 0;
        expect_d("R9 same-cycle sees old", 1, 4'd4);
        look(32'h4000, 4'd1, 2'd0, 8'd1, 8'd1); expect_d("R9 later sees invalid", 0, 4'd0);
        put(4'd4, 1, 32'h4000, 32'h4008, 4'b0001, 8'd0, 1, 8'd0, 1);
        look(32'h4004, 4'd4, 2'd0, 8'd1, 8'd1); expect_d("R9 rewritten entry", 1, 4'd4);
        look(32'h4006, 4'd4, 2'd0, 8'd1, 8'd1); expect_d("R10 fault idx zero", 0, 4'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_bounds();
        t_rights_ids();
        t_overlap();
        t_sides();
        t_write_timing();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule